// File: doc/BRIEF.md
# Dual Word FIFO with Threshold Ready Flags

This block holds two small word queues that sit between a host register interface and a serial shift engine. The transmit queue is filled by the host and drained by the engine. The receive queue is filled by the engine and drained by the host. Each queue has a 3-bit threshold, set by software, that drives a ready flag. Software uses the ready flag to decide when a burst of words can be moved without polling the level one word at a time.

Each queue reports full and empty flags. It also has two sticky error flags: one for a push into a full queue, one for a pop from an empty queue. A single flush command empties both queues and clears all four error flags. After a flush, a busy indication stays high for a fixed number of cycles and then clears by itself. While busy is high, traffic on either side is ignored.

Top module: `dwf_fifo_pair`

## Requirements
- R1: Each queue stores up to 8 words of 32 bits and returns them in the order they were accepted.
- R2: `host_rdata` and `eng_tdata` show the oldest word of their queue in the cycle the pop is presented, before the clock edge that removes it.
- R3: Status bit 7 is transmit full and bit 6 is transmit empty. Bit 5 is receive full and bit 4 is receive empty. Bits 1:0 always read 0.
- R4: Status bit 2 (receive ready) is 1 exactly when the receive level is strictly greater than `rx_thr`.
- R5: Status bit 3 (transmit ready) is 1 exactly when the number of free transmit slots (8 minus the level) is strictly greater than `tx_thr`.
- R6: A push into a full queue is dropped and sets the overflow flag: bit 11 for transmit, bit 9 for receive. A push into a full queue in the same cycle as a pop from it is accepted, and the level stays at 8.
- R7: A pop from an empty queue returns zero, leaves the level at 0, and sets the underflow flag: bit 10 for transmit, bit 8 for receive.
- R8: The overflow and underflow flags stay set across later traffic until a flush or a reset.
- R9: A `flush_req` seen while not busy empties both queues and clears all four error flags at that edge. `flush_busy` then reads 1 for FLUSH_LAT cycles (default 3) and then 0. Pushes, pops and flush requests during those cycles have no effect.
- R10: After reset both queues are empty, all error flags are 0 and `flush_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_thr | input | 3 | Transmit ready threshold |
| rx_thr | input | 3 | Receive ready threshold |
| flush_req | input | 1 | Flush command pulse |
| flush_busy | output | 1 | Flush in progress |
| host_push | input | 1 | Host writes a word into the transmit queue |
| host_wdata | input | 32 | Word written by the host |
| host_pop | input | 1 | Host takes a word from the receive queue |
| host_rdata | output | 32 | Oldest receive word, or zero when empty |
| eng_pop | input | 1 | Engine takes a word from the transmit queue |
| eng_tdata | output | 32 | Oldest transmit word, or zero when empty |
| eng_push | input | 1 | Engine writes a received word |
| eng_rdata | input | 32 | Word written by the engine |
| status | output | 12 | Flag vector laid out as in R3 to R7 |

## Verification
The assertions assume the thresholds are held stable while traffic is checked. They also assume every push or pop is a single-cycle strobe sampled on the rising edge, and that reset is applied before any traffic. The stimulus meets these assumptions in three ways. It changes thresholds only between sweeps. It drives every input on the falling edge and clears it on the next one. It issues flush requests only from the idle state, except in the one case that deliberately repeats a request while busy to show it is ignored. The bench sweeps every threshold against every fill level from 0 to 8 on both queues, and it mirrors the queues in its own model.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

  // Status vector layout: error flags on top, level flags below, ready flags low.
  localparam int ST_W       = 12;
  localparam int ST_TX_OVF  = 11;
  localparam int ST_TX_UDF  = 10;
  localparam int ST_RX_OVF  = 9;
  localparam int ST_RX_UDF  = 8;
  localparam int ST_TX_FULL = 7;
  localparam int ST_TX_EMPT = 6;
  localparam int ST_RX_FULL = 5;
  localparam int ST_RX_EMPT = 4;
  localparam int ST_TX_RDY  = 3;
  localparam int ST_RX_RDY  = 2;

  typedef enum logic { SIDE_FILL = 1'b0, SIDE_DRAIN = 1'b1 } ready_side_e;

  // Number of free slots in a queue of the given depth.
  function automatic int unsigned slots_free(input int unsigned depth,
                                             input int unsigned level);
    return (level >= depth) ? 0 : depth - level;
  endfunction

  // A quantity beats its threshold only when strictly above it.
  function automatic logic beats_thr(input int unsigned amount,
                                     input int unsigned thr);
    return amount > thr;
  endfunction

  // Next pointer with wrap for any depth.
  function automatic int unsigned ptr_next(input int unsigned p,
                                           input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/dwf_slot_fifo.sv
module dwf_slot_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         ovf,
  output logic                         udf
);
  import dwf_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [AW-1:0]    head_q, tail_q;
  logic [CW-1:0]    level_q;

  logic is_empty, is_full;
  logic pop_ok, push_ok, ovf_evt, udf_evt;

  assign is_empty = (level_q == '0);
  assign is_full  = (level_q == CW'(DEPTH));
  assign pop_ok   = pop && !is_empty && !clear;
  assign push_ok  = push && (!is_full || pop_ok) && !clear;
  assign ovf_evt  = push && !clear && is_full && !pop_ok;
  assign udf_evt  = pop && !clear && is_empty;

  // One register per slot, written only when the tail points at it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (tail_q == AW'(i))) slot_q[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      level_q <= '0;
    end else if (clear) begin
      head_q  <= '0;
      tail_q  <= '0;
      level_q <= '0;
    end else begin
      if (pop_ok)  head_q <= AW'(ptr_next(32'(head_q), DEPTH));
      if (push_ok) tail_q <= AW'(ptr_next(32'(tail_q), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else if (clear) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      ovf <= ovf | ovf_evt;
      udf <= udf | udf_evt;
    end
  end

  assign dout  = is_empty ? '0 : slot_q[head_q];
  assign level = level_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH)); // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clear |=> ovf); // R8
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    udf && !clear |=> udf); // R8
  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !clear && is_full |=> level_q == CW'(DEPTH) && ovf); // R6
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pop && is_empty |-> dout == '0); // R7
  AST_EMPTY_POP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && is_empty && !clear |=> level_q == '0 && udf); // R7

endmodule

// File: rtl/dwf_level_flags.sv
module dwf_level_flags #(
  parameter int                   DEPTH = 8,
  parameter dwf_pkg::ready_side_e SIDE  = dwf_pkg::SIDE_FILL
) (
  input  logic [$clog2(DEPTH+1)-1:0] level,
  input  logic [$clog2(DEPTH)-1:0]   thr,
  output logic                       full,
  output logic                       empty,
  output logic                       ready
);
  import dwf_pkg::*;

  localparam int CW = $clog2(DEPTH+1);

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);

  // The transmit side counts free slots; the receive side counts held words.
  if (SIDE == SIDE_FILL) begin : g_free
    assign ready = beats_thr(slots_free(DEPTH, 32'(level)), 32'(thr));
  end else begin : g_held
    assign ready = beats_thr(32'(level), 32'(thr));
  end

endmodule

// File: rtl/dwf_flush_seq.sv
module dwf_flush_seq #(
  parameter int FLUSH_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic start,
  output logic busy
);
  localparam int FCW = $clog2(FLUSH_LAT+1);

  logic [FCW-1:0] left_q;

  assign busy  = (left_q != '0);
  assign start = req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        left_q <= '0;
    else if (start)    left_q <= FCW'(FLUSH_LAT);
    else if (busy)     left_q <= left_q - 1'b1;
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R9

endmodule

// File: rtl/dwf_fifo_pair.sv
module dwf_fifo_pair #(
  parameter int DEPTH     = 8,
  parameter int WIDTH     = 32,
  parameter int FLUSH_LAT = 3,
  localparam int THR_W    = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic             flush_req,
  output logic             flush_busy,
  input  logic             host_push,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_pop,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             eng_pop,
  output logic [WIDTH-1:0] eng_tdata,
  input  logic             eng_push,
  input  logic [WIDTH-1:0] eng_rdata,
  output logic [11:0]      status
);
  import dwf_pkg::*;

  logic          flush_start;
  logic          tx_push_g, tx_pop_g, rx_push_g, rx_pop_g;
  logic [CW-1:0] tx_level, rx_level;
  logic          tx_ovf, tx_udf, rx_ovf, rx_udf;
  logic          tx_full, tx_empty, tx_ready;
  logic          rx_full, rx_empty, rx_ready;

  dwf_flush_seq #(.FLUSH_LAT(FLUSH_LAT)) u_flush (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (flush_req),
    .start (flush_start),
    .busy  (flush_busy)
  );

  // Traffic is frozen while a flush is in progress.
  assign tx_push_g = host_push & ~flush_busy;
  assign tx_pop_g  = eng_pop   & ~flush_busy;
  assign rx_push_g = eng_push  & ~flush_busy;
  assign rx_pop_g  = host_pop  & ~flush_busy;

  dwf_slot_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (flush_start),
    .push  (tx_push_g),
    .din   (host_wdata),
    .pop   (tx_pop_g),
    .dout  (eng_tdata),
    .level (tx_level),
    .ovf   (tx_ovf),
    .udf   (tx_udf)
  );

  dwf_slot_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (flush_start),
    .push  (rx_push_g),
    .din   (eng_rdata),
    .pop   (rx_pop_g),
    .dout  (host_rdata),
    .level (rx_level),
    .ovf   (rx_ovf),
    .udf   (rx_udf)
  );

  dwf_level_flags #(.DEPTH(DEPTH), .SIDE(SIDE_FILL)) u_tx_flags (
    .level (tx_level),
    .thr   (tx_thr),
    .full  (tx_full),
    .empty (tx_empty),
    .ready (tx_ready)
  );

  dwf_level_flags #(.DEPTH(DEPTH), .SIDE(SIDE_DRAIN)) u_rx_flags (
    .level (rx_level),
    .thr   (rx_thr),
    .full  (rx_full),
    .empty (rx_empty),
    .ready (rx_ready)
  );

  always_comb begin
    status             = '0;
    status[ST_TX_OVF]  = tx_ovf;
    status[ST_TX_UDF]  = tx_udf;
    status[ST_RX_OVF]  = rx_ovf;
    status[ST_RX_UDF]  = rx_udf;
    status[ST_TX_FULL] = tx_full;
    status[ST_TX_EMPT] = tx_empty;
    status[ST_RX_FULL] = rx_full;
    status[ST_RX_EMPT] = rx_empty;
    status[ST_TX_RDY]  = tx_ready;
    status[ST_RX_RDY]  = rx_ready;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_start |=> tx_empty && rx_empty && !tx_ovf && !tx_udf && !rx_ovf && !rx_udf); // R9
  AST_BUSY_FREEZE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> $stable(tx_level)); // R9
  AST_BUSY_FREEZE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> $stable(rx_level)); // R9
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty)); // R3

endmodule

// File: tb/dwf_fifo_pair_tb.sv
module dwf_fifo_pair_tb;

  localparam int DEPTH = 8;
  localparam int LAT   = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  tx_thr, rx_thr;
  logic        flush_req, flush_busy;
  logic        host_push, host_pop, eng_pop, eng_push;
  logic [31:0] host_wdata, host_rdata, eng_tdata, eng_rdata;
  logic [11:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model
  logic [31:0] wq[$];
  logic [31:0] rq[$];
  bit wovf, wudf, rovf, rudf;
  int bl = 0;

  always #10 clk = ~clk;

  dwf_fifo_pair #(.DEPTH(DEPTH), .WIDTH(32), .FLUSH_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .host_push(host_push), .host_wdata(host_wdata),
    .host_pop(host_pop), .host_rdata(host_rdata),
    .eng_pop(eng_pop), .eng_tdata(eng_tdata),
    .eng_push(eng_push), .eng_rdata(eng_rdata),
    .status(status)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_status();
    logic [11:0] e = '0;
    int wfree = DEPTH - wq.size();
    e[11] = wovf; e[10] = wudf; e[9] = rovf; e[8] = rudf;
    e[7] = (wq.size() == DEPTH); e[6] = (wq.size() == 0);
    e[5] = (rq.size() == DEPTH); e[4] = (rq.size() == 0);
    e[3] = (wfree > int'(tx_thr));
    e[2] = (rq.size() > int'(rx_thr));
    return e;
  endfunction

  task automatic check_status(input string tag);
    chk({20'b0, status}, {20'b0, exp_status()}, tag);
    chk({31'b0, flush_busy}, {31'b0, bl > 0}, {tag, " busy"});
  endtask

  // Called at a falling edge; applies one cycle of stimulus and returns at the next.
  task automatic drive(input bit hp, input logic [31:0] hd, input bit hpop,
                       input bit ep, input logic [31:0] ed, input bit epop,
                       input bit fr, input string tag);
    bit busy, start, popped;
    host_push = hp; host_wdata = hd; host_pop = hpop;
    eng_push = ep; eng_rdata = ed; eng_pop = epop; flush_req = fr;
    #2;
    busy  = (bl > 0);
    start = fr && !busy;
    if (!start && !busy) begin
      if (hpop) chk(host_rdata, (rq.size() != 0) ? rq[0] : 32'h0, {tag, " R2 host_rdata"});
      if (epop) chk(eng_tdata,  (wq.size() != 0) ? wq[0] : 32'h0, {tag, " R2 eng_tdata"});
    end
    @(negedge clk);
    host_push = 0; host_pop = 0; eng_push = 0; eng_pop = 0; flush_req = 0;
    if (start) begin
      wq.delete(); rq.delete();
      wovf = 0; wudf = 0; rovf = 0; rudf = 0;
      bl = LAT;
    end else if (busy) begin
      bl--;
    end else begin
      popped = 0;
      if (epop) begin
        if (wq.size() == 0) wudf = 1; else begin void'(wq.pop_front()); popped = 1; end
      end
      if (hp) begin
        if (wq.size() < DEPTH) wq.push_back(hd); else wovf = 1;
      end
      popped = 0;
      if (hpop) begin
        if (rq.size() == 0) rudf = 1; else begin void'(rq.pop_front()); popped = 1; end
      end
      if (ep) begin
        if (rq.size() < DEPTH) rq.push_back(ed); else rovf = 1;
      end
    end
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_flush(input string tag);
    drive(0, 0, 0, 0, 0, 0, 1, tag);
    for (int k = 0; k < LAT; k++) idle(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tx_thr = 0; rx_thr = 0; flush_req = 0;
    host_push = 0; host_pop = 0; eng_push = 0; eng_pop = 0;
    host_wdata = 0; eng_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_status("R10 reset state");

    // Full sweep: every threshold against every level on both queues.
    for (int t = 0; t < 8; t++) begin
      tx_thr = 3'(t); rx_thr = 3'(7 - t);
      do_flush("R9 sweep flush");
      for (int n = 0; n <= DEPTH; n++) begin
        if (n > 0)
          drive(1, 32'h1000_0000 + 32'(t * 16 + n), 0, 1, 32'h2000_0000 + 32'(t * 16 + n), 0, 0, "R1 fill");
        check_status("R3 R4 R5 sweep");
      end
    end

    // Overflow at full; simultaneous push and pop at full.
    tx_thr = 3'd4; rx_thr = 3'd2;
    drive(1, 32'hDEAD_0001, 0, 1, 32'hDEAD_0002, 0, 0, "R6 overflow push");
    check_status("R6 overflow flags");
    drive(1, 32'hCAFE_0001, 1, 1, 32'hCAFE_0002, 1, 0, "R6 push+pop at full");
    check_status("R6 full push+pop level");

    // Drain in order, then pop from empty.
    for (int k = 0; k < DEPTH; k++) drive(0, 0, 1, 0, 0, 1, 0, "R1 drain order");
    check_status("R1 drained");
    drive(0, 0, 1, 0, 0, 1, 0, "R7 pop empty");
    check_status("R7 underflow flags");

    // Sticky flags survive further traffic.
    for (int k = 0; k < 5; k++)
      drive(1, 32'h3300_0000 + 32'(k), (k > 2), 1, 32'h4400_0000 + 32'(k), (k > 2), 0, "R8 traffic");
    check_status("R8 flags persist");

    // Flush: busy timing, frozen traffic, repeated request ignored.
    drive(0, 0, 0, 0, 0, 0, 1, "R9 flush start");
    check_status("R9 after flush");
    drive(1, 32'h5555_5555, 1, 1, 32'h6666_6666, 1, 0, "R9 traffic while busy");
    check_status("R9 busy ignores traffic");
    drive(0, 0, 0, 0, 0, 0, 1, "R9 req while busy");
    check_status("R9 busy ignores req");
    idle("R9 idle");
    check_status("R9 busy done");

    // Mixed pattern after flush.
    for (int k = 0; k < 12; k++)
      drive((k % 3) != 2, 32'h7700_0000 + 32'(k * 7), (k % 4) == 3,
            (k % 2) == 0, 32'h8800_0000 + 32'(k * 5), (k % 5) == 4, 0, "R1 mixed");
    check_status("R1 mixed levels");

    // Reset in mid-run.
    drive(1, 32'h9, 0, 0, 0, 1, 0, "R10 pre-reset");
    rst_n = 0;
    #3;
    rst_n = 1;
    wq.delete(); rq.delete(); wovf = 0; wudf = 0; rovf = 0; rudf = 0; bl = 0;
    @(negedge clk);
    check_status("R10 after mid reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule